// File: doc/BRIEF.md
# ECC Error Logging and Interrupt Unit

This unit sits behind an ECC check stage for a memory. That stage sorts every failed check into one of four error classes and reports it as a single-cycle strobe. The strobe carries the class, the word address of the failing access and a bit index. The unit keeps a saturating counter for single-bit errors, one for double-bit errors and one for address-field errors. It keeps a small address queue per category and a sticky per-position record of which data bits and which check bits have been corrected.

Each counter has a programmable threshold. When an increment brings a counter to its threshold, a raw interrupt flag for that category is raised. The flag stays set until it is cleared. Clear inputs zero the counters, the history and the flags. Register decoding is handled elsewhere, so every control here is a plain input and every piece of state is a plain output.

The class routing is deliberately uneven. An address-field error counts as a single error and also as an address error, but its address goes only into the address-error queue. A double error touches only its own counter and queue.

Top module: `ecc_err_log`

## Requirements
- R1: A strobe of class 0 (single data-bit error) adds one to the single-error counter, queues its address in the single-error FIFO and sets `data_hist[evt_bit]`.
- R2: A strobe of class 1 (single address-field error) adds one to both the single-error counter and the address-error counter. It queues its address in the address-error FIFO only and changes no history bit.
- R3: A strobe of class 2 (single check-bit error) adds one to the single-error counter, queues its address in the single-error FIFO and sets `chk_hist[evt_bit]` when `evt_bit` is below 9. Any larger index changes no history bit.
- R4: A strobe of class 3 (double error) adds one to the double-error counter only and queues its address in the double-error FIFO only.
- R5: Counters saturate at their all-ones value (65535 for the 16-bit single-error counter, 15 for the two 4-bit counters) and never wrap.
- R6: Each address FIFO holds 4 entries and returns them oldest first. `*_avail` is high while the FIFO is non-empty and `*_head` shows the oldest entry. A pop on an empty FIFO has no effect. A push and a pop in the same cycle on a full FIFO are both accepted.
- R7: A push into a full FIFO without a pop is dropped and sets the sticky `*_ovf` bit of that FIFO. That bit is cleared only together with its category's counter clear bit, and the clear wins over a same-cycle drop.
- R8: A raw interrupt flag sets in the cycle after an increment makes its counter equal to its non-zero threshold. It stays set until its `irq_clr` bit (bit 0 single, bit 1 double, bit 2 address) is pulsed, and a same-cycle set wins over that clear.
- R9: A threshold of zero never raises its interrupt flag, however many events arrive.
- R10: `cnt_clr` bit 0 zeroes the single-error counter, bit 1 the double-error counter and bit 2 the address-error counter, each independently. A clear wins over a same-cycle increment and leaves the FIFO contents unchanged.
- R11: `hist_clr` zeroes both history bitmaps and wins over a same-cycle history set.
- R12: After synchronous reset, all counters, FIFOs, overflow bits, history bits and interrupt flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event strobe |
| evt_class | input | 2 | Error class: 0 data, 1 address, 2 check bit, 3 double |
| evt_addr | input | ADDR_W (18) | Word address of the failing access |
| evt_bit | input | IDX_W (7) | Corrected data-bit or check-bit position |
| thr_sec | input | SEC_W (16) | Single-error interrupt threshold, 0 disables |
| thr_ded | input | DED_W (4) | Double-error interrupt threshold, 0 disables |
| thr_adr | input | ADR_W (4) | Address-error interrupt threshold, 0 disables |
| cnt_clr | input | 3 | Per-category counter and overflow clear |
| hist_clr | input | 1 | Clear both history bitmaps |
| irq_clr | input | 3 | Per-category interrupt flag clear |
| sec_pop | input | 1 | Pop single-error FIFO |
| ded_pop | input | 1 | Pop double-error FIFO |
| adr_pop | input | 1 | Pop address-error FIFO |
| cnt_sec | output | SEC_W (16) | Single-error count |
| cnt_ded | output | DED_W (4) | Double-error count |
| cnt_adr | output | ADR_W (4) | Address-error count |
| sec_head | output | ADDR_W (18) | Oldest single-error address |
| sec_avail | output | 1 | Single-error FIFO non-empty |
| sec_ovf | output | 1 | Single-error FIFO dropped an address |
| ded_head | output | ADDR_W (18) | Oldest double-error address |
| ded_avail | output | 1 | Double-error FIFO non-empty |
| ded_ovf | output | 1 | Double-error FIFO dropped an address |
| adr_head | output | ADDR_W (18) | Oldest address-error address |
| adr_avail | output | 1 | Address-error FIFO non-empty |
| adr_ovf | output | 1 | Address-error FIFO dropped an address |
| data_hist | output | DATA_BITS (128) | Sticky corrected data-bit positions |
| chk_hist | output | CHK_BITS (9) | Sticky corrected check-bit positions |
| irq_sec | output | 1 | Single-error raw interrupt |
| irq_ded | output | 1 | Double-error raw interrupt |
| irq_adr | output | 1 | Address-error raw interrupt |

## Verification
The assertions check every cycle that counters move by at most one and hold at saturation, that a double error leaves the single-error count alone, and that an address-field error always advances the address counter. They also check that overflow bits, interrupt flags and history bits stay set until their own clear, and that a zero threshold keeps its flag low. The bench scenarios show what a property cannot easily follow: which FIFO receives each address and in what order, dropping at a full queue, the exact cycle in which a threshold is reached, and the priority of clears over same-cycle events. They also cover the full sweep of data-bit and check-bit positions, including indexes past the check-bit range.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    typedef enum logic [1:0] {
        CLS_DATA = 2'd0,
        CLS_ADDR = 2'd1,
        CLS_CHK  = 2'd2,
        CLS_DBL  = 2'd3
    } err_cls_e;

    localparam int NCAT    = 3;
    localparam int CAT_SEC = 0;
    localparam int CAT_DED = 1;
    localparam int CAT_ADR = 2;

    typedef struct packed {
        logic [NCAT-1:0] inc;
        logic [NCAT-1:0] push;
        logic            hdata;
        logic            hchk;
    } route_t;

    function automatic route_t route_f(logic vld, err_cls_e cls);
        route_t r;
        r = '0;
        if (vld) begin
            unique case (cls)
                CLS_DATA: begin
                    r.inc[CAT_SEC]  = 1'b1;
                    r.push[CAT_SEC] = 1'b1;
                    r.hdata         = 1'b1;
                end
                CLS_ADDR: begin
                    r.inc[CAT_SEC]  = 1'b1;
                    r.inc[CAT_ADR]  = 1'b1;
                    r.push[CAT_ADR] = 1'b1;
                end
                CLS_CHK: begin
                    r.inc[CAT_SEC]  = 1'b1;
                    r.push[CAT_SEC] = 1'b1;
                    r.hchk          = 1'b1;
                end
                CLS_DBL: begin
                    r.inc[CAT_DED]  = 1'b1;
                    r.push[CAT_DED] = 1'b1;
                end
                default: r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_log_cnt.sv
module ecc_log_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    input  logic [W-1:0] thr,
    input  logic         irq_clr,
    output logic [W-1:0] cnt,
    output logic         irq
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] nxt;
    logic         hit;

    always_comb begin
        if (clr)
            nxt = '0;
        else if (inc && cnt != MAXV)
            nxt = cnt + 1'b1;
        else
            nxt = cnt;
        hit = inc && !clr && (thr != '0) && (nxt == thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            cnt <= nxt;
            if (hit)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
        end
    end
endmodule

// File: rtl/ecc_log_fifo.sv
module ecc_log_fifo #(
    parameter int DW    = 18,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    input  logic          clr_ovf,
    output logic [DW-1:0] head,
    output logic          avail,
    output logic          ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_p, wr_p;
    logic [CW-1:0] fill;
    logic          pop_e, push_e, drop;

    always_comb begin
        pop_e  = pop && (fill != '0);
        push_e = push && ((fill != FULLC) || pop_e);
        drop   = push && !push_e;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p <= '0;
            wr_p <= '0;
            fill <= '0;
            ovf  <= 1'b0;
        end else begin
            if (pop_e)
                rd_p <= (rd_p == LASTP) ? '0 : rd_p + 1'b1;
            if (push_e)
                wr_p <= (wr_p == LASTP) ? '0 : wr_p + 1'b1;
            fill <= fill + CW'(push_e) - CW'(pop_e);
            if (clr_ovf)
                ovf <= 1'b0;
            else if (drop)
                ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_e)
            mem[wr_p] <= din;
    end

    assign head  = mem[rd_p];
    assign avail = (fill != '0);
endmodule

// File: rtl/ecc_log_hist.sv
module ecc_log_hist #(
    parameter int N  = 128,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set,
    input  logic [IW-1:0] idx,
    input  logic          clr,
    output logic [N-1:0]  hist
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr)
                hist[i] <= 1'b0;
            else if (set && idx == IW'(i))
                hist[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_BITS  = 128,
    parameter int CHK_BITS   = 9,
    parameter int SEC_W      = 16,
    parameter int DED_W      = 4,
    parameter int ADR_W      = 4,
    parameter int FIFO_DEPTH = 4,
    localparam int IDX_W     = $clog2(DATA_BITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 evt_valid,
    input  logic [1:0]           evt_class,
    input  logic [ADDR_W-1:0]    evt_addr,
    input  logic [IDX_W-1:0]     evt_bit,
    input  logic [SEC_W-1:0]     thr_sec,
    input  logic [DED_W-1:0]     thr_ded,
    input  logic [ADR_W-1:0]     thr_adr,
    input  logic [2:0]           cnt_clr,
    input  logic                 hist_clr,
    input  logic [2:0]           irq_clr,
    input  logic                 sec_pop,
    input  logic                 ded_pop,
    input  logic                 adr_pop,
    output logic [SEC_W-1:0]     cnt_sec,
    output logic [DED_W-1:0]     cnt_ded,
    output logic [ADR_W-1:0]     cnt_adr,
    output logic [ADDR_W-1:0]    sec_head,
    output logic                 sec_avail,
    output logic                 sec_ovf,
    output logic [ADDR_W-1:0]    ded_head,
    output logic                 ded_avail,
    output logic                 ded_ovf,
    output logic [ADDR_W-1:0]    adr_head,
    output logic                 adr_avail,
    output logic                 adr_ovf,
    output logic [DATA_BITS-1:0] data_hist,
    output logic [CHK_BITS-1:0]  chk_hist,
    output logic                 irq_sec,
    output logic                 irq_ded,
    output logic                 irq_adr
);
    route_t            rt;
    logic [NCAT-1:0]   pops;
    logic [NCAT-1:0]   avails;
    logic [NCAT-1:0]   ovfs;
    logic [ADDR_W-1:0] heads [NCAT];

    always_comb rt = route_f(evt_valid, err_cls_e'(evt_class));

    ecc_log_cnt #(.W(SEC_W)) u_cnt_sec (
        .clk(clk), .rst(rst), .inc(rt.inc[CAT_SEC]), .clr(cnt_clr[CAT_SEC]),
        .thr(thr_sec), .irq_clr(irq_clr[CAT_SEC]), .cnt(cnt_sec), .irq(irq_sec)
    );
    ecc_log_cnt #(.W(DED_W)) u_cnt_ded (
        .clk(clk), .rst(rst), .inc(rt.inc[CAT_DED]), .clr(cnt_clr[CAT_DED]),
        .thr(thr_ded), .irq_clr(irq_clr[CAT_DED]), .cnt(cnt_ded), .irq(irq_ded)
    );
    ecc_log_cnt #(.W(ADR_W)) u_cnt_adr (
        .clk(clk), .rst(rst), .inc(rt.inc[CAT_ADR]), .clr(cnt_clr[CAT_ADR]),
        .thr(thr_adr), .irq_clr(irq_clr[CAT_ADR]), .cnt(cnt_adr), .irq(irq_adr)
    );

    assign pops[CAT_SEC] = sec_pop;
    assign pops[CAT_DED] = ded_pop;
    assign pops[CAT_ADR] = adr_pop;

    for (genvar g = 0; g < NCAT; g++) begin : g_fifo
        ecc_log_fifo #(.DW(ADDR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst(rst), .push(rt.push[g]), .din(evt_addr),
            .pop(pops[g]), .clr_ovf(cnt_clr[g]),
            .head(heads[g]), .avail(avails[g]), .ovf(ovfs[g])
        );
    end

    assign sec_head  = heads[CAT_SEC];
    assign sec_avail = avails[CAT_SEC];
    assign sec_ovf   = ovfs[CAT_SEC];
    assign ded_head  = heads[CAT_DED];
    assign ded_avail = avails[CAT_DED];
    assign ded_ovf   = ovfs[CAT_DED];
    assign adr_head  = heads[CAT_ADR];
    assign adr_avail = avails[CAT_ADR];
    assign adr_ovf   = ovfs[CAT_ADR];

    ecc_log_hist #(.N(DATA_BITS), .IW(IDX_W)) u_hist_data (
        .clk(clk), .rst(rst), .set(rt.hdata), .idx(evt_bit),
        .clr(hist_clr), .hist(data_hist)
    );
    ecc_log_hist #(.N(CHK_BITS), .IW(IDX_W)) u_hist_chk (
        .clk(clk), .rst(rst), .set(rt.hchk), .idx(evt_bit),
        .clr(hist_clr), .hist(chk_hist)
    );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_log_pkg::*;
#(
    parameter int DATA_BITS = 128,
    parameter int CHK_BITS  = 9,
    parameter int SEC_W     = 16,
    parameter int DED_W     = 4,
    parameter int ADR_W     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 evt_valid,
    input logic [1:0]           evt_class,
    input logic [ADR_W-1:0]     thr_adr,
    input logic [2:0]           cnt_clr,
    input logic                 hist_clr,
    input logic [2:0]           irq_clr,
    input logic [SEC_W-1:0]     cnt_sec,
    input logic [ADR_W-1:0]     cnt_adr,
    input logic                 sec_ovf,
    input logic [DATA_BITS-1:0] data_hist,
    input logic [CHK_BITS-1:0]  chk_hist,
    input logic                 irq_ded,
    input logic                 irq_adr
);
    localparam logic [SEC_W-1:0] SEC_MAX = '1;
    localparam logic [ADR_W-1:0] ADR_MAX = '1;

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr[0] |=> (cnt_sec == $past(cnt_sec) || cnt_sec == $past(cnt_sec) + 1'b1));

    p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr[0] && cnt_sec == SEC_MAX) |=> cnt_sec == SEC_MAX);

    p_dbl_no_sec_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_class == CLS_DBL && !cnt_clr[0]) |=> $stable(cnt_sec));

    p_addr_counts_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_class == CLS_ADDR && cnt_adr != ADR_MAX && !cnt_clr[2])
        |=> cnt_adr == $past(cnt_adr) + 1'b1);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (sec_ovf && !cnt_clr[0]) |=> sec_ovf);

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_ded && !irq_clr[1]) |=> irq_ded);

    p_thr_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (thr_adr == '0 && !irq_adr) |=> !irq_adr);

    p_hist_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        !hist_clr |=> ((data_hist & $past(data_hist)) == $past(data_hist)
                       && (chk_hist & $past(chk_hist)) == $past(chk_hist)));

    p_hist_clr_r11: assert property (@(posedge clk) disable iff (rst)
        hist_clr |=> (data_hist == '0 && chk_hist == '0));
endmodule

bind ecc_err_log ecc_err_log_chk #(
    .DATA_BITS(DATA_BITS), .CHK_BITS(CHK_BITS),
    .SEC_W(SEC_W), .DED_W(DED_W), .ADR_W(ADR_W)
) u_chk (.*);

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic         ev_v = 0;
    logic [1:0]   ev_c = 0;
    logic [17:0]  ev_a = 0;
    logic [6:0]   ev_b = 0;
    logic [15:0]  t_sec = 0;
    logic [3:0]   t_ded = 0;
    logic [3:0]   t_adr = 0;
    logic [2:0]   c_clr = 0;
    logic         h_clr = 0;
    logic [2:0]   i_clr = 0;
    logic [2:0]   pops = 0;

    logic [15:0]  cnt_sec;
    logic [3:0]   cnt_ded, cnt_adr;
    logic [17:0]  sec_head, ded_head, adr_head;
    logic         sec_avail, ded_avail, adr_avail;
    logic         sec_ovf, ded_ovf, adr_ovf;
    logic [127:0] data_hist;
    logic [8:0]   chk_hist;
    logic         irq_sec, irq_ded, irq_adr;

    ecc_err_log u0 (
        .clk(clk), .rst(rst), .evt_valid(ev_v), .evt_class(ev_c), .evt_addr(ev_a),
        .evt_bit(ev_b), .thr_sec(t_sec), .thr_ded(t_ded), .thr_adr(t_adr),
        .cnt_clr(c_clr), .hist_clr(h_clr), .irq_clr(i_clr),
        .sec_pop(pops[0]), .ded_pop(pops[1]), .adr_pop(pops[2]),
        .cnt_sec(cnt_sec), .cnt_ded(cnt_ded), .cnt_adr(cnt_adr),
        .sec_head(sec_head), .sec_avail(sec_avail), .sec_ovf(sec_ovf),
        .ded_head(ded_head), .ded_avail(ded_avail), .ded_ovf(ded_ovf),
        .adr_head(adr_head), .adr_avail(adr_avail), .adr_ovf(adr_ovf),
        .data_hist(data_hist), .chk_hist(chk_hist),
        .irq_sec(irq_sec), .irq_ded(irq_ded), .irq_adr(irq_adr)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state, derived from the requirements
    int           m_cnt [3];
    int           m_max [3];
    bit           m_irq [3];
    int           q     [3][4];
    int           qn    [3];
    bit           m_ovf [3];
    logic [127:0] m_dh;
    logic [8:0]   m_ch;

    function automatic int thr_of(int k);
        case (k)
            0: return int'(t_sec);
            1: return int'(t_ded);
            default: return int'(t_adr);
        endcase
    endfunction

    task automatic model_update();
        bit inc [3];
        bit psh [3];
        bit hd, hc;
        for (int k = 0; k < 3; k++) begin inc[k] = 0; psh[k] = 0; end
        hd = 0; hc = 0;
        if (ev_v) begin
            case (ev_c)
                2'd0: begin inc[0] = 1; psh[0] = 1; hd = 1; end
                2'd1: begin inc[0] = 1; inc[2] = 1; psh[2] = 1; end
                2'd2: begin inc[0] = 1; psh[0] = 1; hc = 1; end
                default: begin inc[1] = 1; psh[1] = 1; end
            endcase
        end
        for (int k = 0; k < 3; k++) begin
            int  nc;
            bit  hit, pe, pu, drop;
            if (c_clr[k]) nc = 0;
            else if (inc[k] && m_cnt[k] < m_max[k]) nc = m_cnt[k] + 1;
            else nc = m_cnt[k];
            hit = inc[k] && !c_clr[k] && thr_of(k) != 0 && nc == thr_of(k);
            if (hit) m_irq[k] = 1;
            else if (i_clr[k]) m_irq[k] = 0;
            m_cnt[k] = nc;
            pe = pops[k] && qn[k] > 0;
            pu = psh[k] && (qn[k] < 4 || pe);
            drop = psh[k] && !pu;
            if (pe) begin
                for (int j = 0; j < 3; j++) q[k][j] = q[k][j+1];
                qn[k]--;
            end
            if (pu) begin q[k][qn[k]] = int'(ev_a); qn[k]++; end
            if (c_clr[k]) m_ovf[k] = 0;
            else if (drop) m_ovf[k] = 1;
        end
        if (h_clr) begin
            m_dh = '0; m_ch = '0;
        end else begin
            if (hd) m_dh[ev_b] = 1'b1;
            if (hc && ev_b < 9) m_ch[ev_b[3:0]] = 1'b1;
        end
    endtask

    task automatic tick();
        model_update();
        @(posedge clk);
        @(negedge clk);
        ev_v = 0; c_clr = 0; h_clr = 0; i_clr = 0; pops = 0;
    endtask

    task automatic cmp(string r, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    function automatic longint d_cnt(int k);
        case (k) 0: return cnt_sec; 1: return cnt_ded; default: return cnt_adr; endcase
    endfunction
    function automatic longint d_head(int k);
        case (k) 0: return sec_head; 1: return ded_head; default: return adr_head; endcase
    endfunction
    function automatic bit d_avail(int k);
        case (k) 0: return sec_avail; 1: return ded_avail; default: return adr_avail; endcase
    endfunction
    function automatic bit d_ovf(int k);
        case (k) 0: return sec_ovf; 1: return ded_ovf; default: return adr_ovf; endcase
    endfunction
    function automatic bit d_irq(int k);
        case (k) 0: return irq_sec; 1: return irq_ded; default: return irq_adr; endcase
    endfunction

    task automatic check_all(string r);
        for (int k = 0; k < 3; k++) begin
            cmp(r, $sformatf("count[%0d]", k), d_cnt(k), m_cnt[k]);
            cmp(r, $sformatf("avail[%0d]", k), d_avail(k), qn[k] > 0);
            if (qn[k] > 0) cmp(r, $sformatf("head[%0d]", k), d_head(k), q[k][0]);
            cmp(r, $sformatf("ovf[%0d]", k), d_ovf(k), m_ovf[k]);
            cmp(r, $sformatf("irq[%0d]", k), d_irq(k), m_irq[k]);
        end
        n_cmp++;
        if (data_hist !== m_dh) begin
            n_bad++;
            $display("FAIL %s data_hist: actual %h expected %h", r, data_hist, m_dh);
        end
        cmp(r, "chk_hist", chk_hist, m_ch);
    endtask

    task automatic send(int c, int a, int b, logic [2:0] p);
        ev_v = 1; ev_c = 2'(c); ev_a = 18'(a); ev_b = 7'(b); pops = p;
        tick();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_max[0] = 65535; m_max[1] = 15; m_max[2] = 15;
        for (int k = 0; k < 3; k++) begin
            m_cnt[k] = 0; m_irq[k] = 0; qn[k] = 0; m_ovf[k] = 0;
        end
        m_dh = '0; m_ch = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R12");

        t_sec = 3; t_ded = 2; t_adr = 1;
        send(0, 'h101, 5, 3'b000);   check_all("R1");
        send(1, 'h202, 0, 3'b000);   check_all("R2");
        send(2, 'h303, 3, 3'b000);   check_all("R3");
        send(2, 'h304, 12, 3'b000);  check_all("R3");
        send(3, 'h405, 0, 3'b000);   check_all("R4");
        send(3, 'h406, 0, 3'b000);   check_all("R8");
        i_clr = 3'b111; tick();      check_all("R8");
        // set wins over clear in the same cycle
        t_adr = 2; i_clr = 3'b100; send(1, 'h207, 0, 3'b000); check_all("R8");

        // FIFO order, pop on empty
        for (int i = 0; i < 4; i++) begin
            pops = 3'b111; tick(); check_all("R6");
        end

        // fill double FIFO past depth
        for (int i = 0; i < 6; i++) begin
            send(3, 'h500 + i, 0, 3'b000); check_all("R7");
        end
        send(3, 'h510, 0, 3'b010); check_all("R6");
        c_clr = 3'b010; send(3, 'h511, 0, 3'b000); check_all("R7");
        check_all("R10");

        // sweep all data-bit positions, draining as we go
        for (int b = 0; b < 128; b++) begin
            send(0, 'h1000 + b, b, 3'b001); check_all("R1");
        end
        for (int b = 0; b < 16; b++) begin
            send(2, 'h2000 + b, b, 3'b001); check_all("R3");
        end
        h_clr = 1; send(0, 'h3000, 77, 3'b000); check_all("R11");
        send(2, 'h3001, 8, 3'b000); check_all("R3");
        h_clr = 1; tick(); check_all("R11");

        // per-bit counter clears, with an event in the same cycle
        for (int k = 0; k < 3; k++) begin
            c_clr = 3'(1 << k); send(1, 'h4000 + k, 0, 3'b111); check_all("R10");
        end

        // zero threshold and saturation of the 4-bit counters
        t_adr = 0; t_ded = 0; i_clr = 3'b111; tick();
        for (int i = 0; i < 20; i++) begin
            send(1, 'h5000 + i, 0, 3'b100); check_all("R9");
            send(3, 'h6000 + i, 0, 3'b010); check_all("R5");
        end

        // 16-bit saturation
        t_sec = 16'hFFFF;
        for (int i = 0; i < 65540; i++) begin
            ev_v = 1; ev_c = 2'd0; ev_a = 18'(i); ev_b = 7'(i); pops = 3'b001;
            tick();
        end
        check_all("R5");
        send(2, 'h7777, 4, 3'b000); check_all("R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule